// File: doc/BRIEF.md
# Bus Comparator Trigger Unit

This unit snoops a CPU bus every clock cycle (address, data, read/write direction and a valid strobe) and compares each valid cycle with two programmable comparator words, A and B. Software picks one of nine trigger conditions. The unit then raises a one-cycle trigger pulse that a trace buffer uses as its start or stop mark. A single control bit switches the unit to breakpoint operation instead. In that mode, a match raises a one-cycle breakpoint request, and a destination bit routes it to background-debug entry or to a software interrupt. Trace triggering and breakpoints never run at the same time.

Software programs the unit through a small write port with four word registers. The control register (index 0) holds the arm bit 0, breakpoint enable bit 1, destination bit 2 (1 means software interrupt, 0 means background debug), breakpoint sub-mode bit 3 (1 means address and data, 0 means either address) and the trace begin/end bit 4. The mode register (index 1) holds the condition code in bits 3:0, the A direction-qualifier enable and value in bits 4 and 5, and the B direction-qualifier enable and value in bits 6 and 7. Index 2 holds comparator A and index 3 holds comparator B. In the full-match conditions, B supplies the data value.

The sequencer has four states. IDLE means disarmed. ARMED means waiting for a hit. A_SEEN means the first half of a sequential condition has matched. FIRED means the unit has triggered. The transitions are:
- arm (any state to ARMED, on a control write with bit 0 set)
- disarm (any state to IDLE, on a control write with bit 0 clear)
- first-half (ARMED to A_SEEN)
- fire (ARMED or A_SEEN to FIRED)
- restart (A_SEEN to ARMED, on a mode write)

A register write takes priority over a bus hit in the same cycle.

Top module: `bus_trig_unit`

## Requirements
- R1: While reset is low, trig, bkpt_req, armed and triggered are all 0.
- R2: A control write with bit 0 set arms the unit (armed is 1 in the next cycle, triggered is 0), whatever state it was in. A control write with bit 0 clear disarms it and clears triggered. A bus hit that falls in the same cycle as a control or mode write has no effect.
- R3: Condition 0 fires on a valid cycle whose address equals A and whose direction passes A's qualifier. Condition 3 fires on a valid cycle whose address equals B, whatever the direction and whatever B's qualifier.
- R4: Condition 1 fires on a valid cycle that passes the address-and-qualifier test of A or of B.
- R5: Conditions 2 and 4 fire only on a B hit in a cycle later than the A hit. The cycle that records A never fires, even if its address also equals B. Condition 2 applies B's direction qualifier, and condition 4 ignores it.
- R6: Condition 5 fires when the address equals A and the data equals B. Condition 6 fires when the address equals A and the data differs from B. Both apply A's qualifier.
- R7: Condition 7 fires when A ≤ address ≤ B (bounds included). Condition 8 fires when the address is below A or above B. Both apply A's qualifier.
- R8: Condition codes 9 to 15 never fire, and the unit stays armed.
- R9: When a comparator's qualifier enable is set, that comparator matches only cycles whose bus_rw (1 means read) equals its qualifier value.
- R10: A cycle with bus_valid low never matches.
- R11: A trigger appears as a one-cycle pulse in the cycle after the bus cycle that caused it. At the same edge, armed drops and triggered rises. No further pulse occurs until the unit is re-armed.
- R12: With breakpoint enable set, trig stays 0 and the condition code is ignored. Sub-mode 0 fires on an A or B address hit. Sub-mode 1 fires when the address equals A and the data equals B. The hit appears as a one-cycle bkpt_req pulse, and bkpt_swi shows control bit 2.
- R13: trig_begin shows control bit 4 from the cycle after the write.
- R14: A mode write, a re-arm or a disarm discards a recorded A half, so a following B hit alone does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index |
| wr_data | input | W | Register write data |
| bus_valid | input | 1 | Snooped cycle is a real bus transfer |
| bus_rw | input | 1 | Snooped direction, 1 = read |
| bus_addr | input | W | Snooped address |
| bus_data | input | W | Snooped data |
| trig | output | 1 | Trace trigger pulse |
| trig_begin | output | 1 | 1 = trigger starts capture, 0 = ends it |
| bkpt_req | output | 1 | Breakpoint request pulse |
| bkpt_swi | output | 1 | Breakpoint destination, 1 = software interrupt |
| armed | output | 1 | Unit armed and waiting |
| triggered | output | 1 | Unit has fired since last arm |

## Verification
Every bus-driven result is registered once. trig, bkpt_req, armed and triggered therefore change at the same rising edge that samples the bus cycle, one cycle after the stimulus. trig_begin and bkpt_swi follow a control write at the next edge. The bench applies each stimulus at a falling edge and reads the outputs at the following falling edge, which is half a period after the edge where they are due. For sequential conditions it steps through the A cycle, then the B cycle, and checks after each one.

// File: rtl/btu_pkg.sv
package btu_pkg;

    localparam int unsigned MODE_W  = 4;
    localparam int unsigned RADDR_W = 2;

    // register indices
    localparam logic [RADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [RADDR_W-1:0] REG_MODE = 2'd1;
    localparam logic [RADDR_W-1:0] REG_CMPA = 2'd2;
    localparam logic [RADDR_W-1:0] REG_CMPB = 2'd3;

    // control register bit positions
    localparam int unsigned CB_ARM   = 0;
    localparam int unsigned CB_BKPT  = 1;
    localparam int unsigned CB_SWI   = 2;
    localparam int unsigned CB_FULL  = 3;
    localparam int unsigned CB_BEGIN = 4;

    typedef enum logic [MODE_W-1:0] {
        TM_A_ONLY         = 4'd0,
        TM_A_OR_B         = 4'd1,
        TM_A_THEN_B       = 4'd2,
        TM_B_EVENT        = 4'd3,
        TM_A_THEN_B_EVENT = 4'd4,
        TM_ADDR_A_DATA_B  = 4'd5,
        TM_ADDR_A_DATA_NB = 4'd6,
        TM_INSIDE         = 4'd7,
        TM_OUTSIDE        = 4'd8
    } trig_mode_e;

    typedef struct packed {
        logic trig_begin;
        logic bkpt_full;
        logic bkpt_swi;
        logic bkpt_en;
    } ctrl_t;

    typedef struct packed {
        logic              b_rw_val;
        logic              b_rw_en;
        logic              a_rw_val;
        logic              a_rw_en;
        logic [MODE_W-1:0] sel;
    } mode_t;

    localparam int unsigned MODE_BITS = $bits(mode_t);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_A_SEEN = 2'd2,
        ST_FIRED  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/btu_regs.sv
module btu_regs
    import btu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RADDR_W-1:0] wr_addr,
    input  logic [W-1:0]       wr_data,
    output ctrl_t              ctrl,
    output mode_t              mode,
    output logic [W-1:0]       cmp_a,
    output logic [W-1:0]       cmp_b,
    output logic               ctrl_wr,
    output logic               mode_wr,
    output logic               arm_bit
);

    ctrl_t        ctrl_q;
    mode_t        mode_q;
    logic [W-1:0] cmp_a_q;
    logic [W-1:0] cmp_b_q;

    assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
    assign mode_wr = wr_en && (wr_addr == REG_MODE);
    assign arm_bit = wr_data[CB_ARM];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_CTRL: ctrl_q <= '{trig_begin: wr_data[CB_BEGIN],
                                      bkpt_full:  wr_data[CB_FULL],
                                      bkpt_swi:   wr_data[CB_SWI],
                                      bkpt_en:    wr_data[CB_BKPT]};
                REG_MODE: mode_q  <= mode_t'(wr_data[MODE_BITS-1:0]);
                REG_CMPA: cmp_a_q <= wr_data;
                REG_CMPB: cmp_b_q <= wr_data;
            endcase
        end
    end

    assign ctrl  = ctrl_q;
    assign mode  = mode_q;
    assign cmp_a = cmp_a_q;
    assign cmp_b = cmp_b_q;

endmodule

// File: rtl/btu_match.sv
module btu_match
    import btu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         bkpt_en,
    input  logic         bkpt_full,
    input  mode_t        mode,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         bus_valid,
    input  logic         bus_rw,
    input  logic [W-1:0] bus_addr,
    input  logic [W-1:0] bus_data,
    output logic         direct_hit,
    output logic         is_seq,
    output logic         seq_a,
    output logic         seq_b
);

    localparam int unsigned NCMP = 2;

    logic [W-1:0]    ref_word [NCMP];
    logic [NCMP-1:0] q_en;
    logic [NCMP-1:0] q_val;
    logic [NCMP-1:0] addr_eq;
    logic [NCMP-1:0] dir_ok;
    logic [NCMP-1:0] hit;

    assign ref_word[0] = cmp_a;
    assign ref_word[1] = cmp_b;
    assign q_en        = {mode.b_rw_en,  mode.a_rw_en};
    assign q_val       = {mode.b_rw_val, mode.a_rw_val};

    // one address comparator with direction qualifier per register
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign addr_eq[i] = (bus_addr == ref_word[i]);
        assign dir_ok[i]  = !q_en[i] || (bus_rw == q_val[i]);
        assign hit[i]     = bus_valid && addr_eq[i] && dir_ok[i];
    end

    logic data_eq;
    logic at_or_above_a;
    logic at_or_below_b;
    logic b_any_dir;
    logic a_live;

    assign data_eq       = (bus_data == cmp_b);
    assign at_or_above_a = (bus_addr >= cmp_a);
    assign at_or_below_b = (bus_addr <= cmp_b);
    assign b_any_dir     = bus_valid && addr_eq[1];
    assign a_live        = bus_valid && dir_ok[0];

    assign seq_a = hit[0];

    always_comb begin
        direct_hit = 1'b0;
        is_seq     = 1'b0;
        seq_b      = hit[1];
        if (bkpt_en) begin
            direct_hit = bkpt_full ? (hit[0] && data_eq) : (hit[0] || hit[1]);
        end else begin
            case (mode.sel)
                TM_A_ONLY:         direct_hit = hit[0];
                TM_A_OR_B:         direct_hit = hit[0] || hit[1];
                TM_A_THEN_B:       is_seq     = 1'b1;
                TM_B_EVENT:        direct_hit = b_any_dir;
                TM_A_THEN_B_EVENT: begin
                    is_seq = 1'b1;
                    seq_b  = b_any_dir;
                end
                TM_ADDR_A_DATA_B:  direct_hit = hit[0] && data_eq;
                TM_ADDR_A_DATA_NB: direct_hit = hit[0] && !data_eq;
                TM_INSIDE:         direct_hit = a_live && at_or_above_a && at_or_below_b;
                TM_OUTSIDE:        direct_hit = a_live && (!at_or_above_a || !at_or_below_b);
                default:           direct_hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/btu_fsm.sv
module btu_fsm
    import btu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic arm_bit,
    input  logic mode_wr,
    input  logic bkpt_en,
    input  logic is_seq,
    input  logic seq_a,
    input  logic seq_b,
    input  logic direct_hit,
    output logic trig,
    output logic bkpt_req,
    output logic armed,
    output logic triggered
);

    seq_state_e st_q;
    seq_state_e st_d;
    logic       fire;

    // next state
    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (ctrl_wr) begin
            st_d = arm_bit ? ST_ARMED : ST_IDLE;
        end else if (mode_wr && (st_q == ST_ARMED || st_q == ST_A_SEEN)) begin
            st_d = ST_ARMED;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_ARMED: begin
                    if (is_seq) begin
                        if (seq_a) st_d = ST_A_SEEN;
                    end else if (direct_hit) begin
                        st_d = ST_FIRED;
                        fire = 1'b1;
                    end
                end
                ST_A_SEEN: begin
                    if (seq_b) begin
                        st_d = ST_FIRED;
                        fire = 1'b1;
                    end
                end
                ST_FIRED: st_d = ST_FIRED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // registered outputs
    logic trig_q;
    logic bkpt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            bkpt_q <= 1'b0;
        end else begin
            trig_q <= fire && !bkpt_en;
            bkpt_q <= fire && bkpt_en;
        end
    end

    assign trig      = trig_q;
    assign bkpt_req  = bkpt_q;
    assign armed     = (st_q == ST_ARMED) || (st_q == ST_A_SEEN);
    assign triggered = (st_q == ST_FIRED);

endmodule

// File: rtl/bus_trig_unit.sv
module bus_trig_unit
    import btu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RADDR_W-1:0] wr_addr,
    input  logic [W-1:0]       wr_data,
    input  logic               bus_valid,
    input  logic               bus_rw,
    input  logic [W-1:0]       bus_addr,
    input  logic [W-1:0]       bus_data,
    output logic               trig,
    output logic               trig_begin,
    output logic               bkpt_req,
    output logic               bkpt_swi,
    output logic               armed,
    output logic               triggered
);

    ctrl_t        ctrl;
    mode_t        mode;
    logic [W-1:0] cmp_a;
    logic [W-1:0] cmp_b;
    logic         ctrl_wr;
    logic         mode_wr;
    logic         arm_bit;
    logic         direct_hit;
    logic         is_seq;
    logic         seq_a;
    logic         seq_b;

    btu_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .mode    (mode),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .ctrl_wr (ctrl_wr),
        .mode_wr (mode_wr),
        .arm_bit (arm_bit)
    );

    btu_match #(.W(W)) u_match (
        .bkpt_en    (ctrl.bkpt_en),
        .bkpt_full  (ctrl.bkpt_full),
        .mode       (mode),
        .cmp_a      (cmp_a),
        .cmp_b      (cmp_b),
        .bus_valid  (bus_valid),
        .bus_rw     (bus_rw),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .direct_hit (direct_hit),
        .is_seq     (is_seq),
        .seq_a      (seq_a),
        .seq_b      (seq_b)
    );

    btu_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .arm_bit    (arm_bit),
        .mode_wr    (mode_wr),
        .bkpt_en    (ctrl.bkpt_en),
        .is_seq     (is_seq),
        .seq_a      (seq_a),
        .seq_b      (seq_b),
        .direct_hit (direct_hit),
        .trig       (trig),
        .bkpt_req   (bkpt_req),
        .armed      (armed),
        .triggered  (triggered)
    );

    assign trig_begin = ctrl.trig_begin;
    assign bkpt_swi   = ctrl.bkpt_swi;

endmodule

// File: rtl/btu_chk.sv
module btu_chk
    import btu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [RADDR_W-1:0] wr_addr,
    input logic [W-1:0]       wr_data,
    input logic               trig,
    input logic               bkpt_req,
    input logic               armed,
    input logic               triggered
);

    logic         arm_wr;
    logic         disarm_wr;
    logic [W-2:0] unused_wr_bits;

    assign arm_wr         = wr_en && (wr_addr == REG_CTRL) && wr_data[CB_ARM];
    assign disarm_wr      = wr_en && (wr_addr == REG_CTRL) && !wr_data[CB_ARM];
    assign unused_wr_bits = wr_data[W-1:1];

    // R2
    arm_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (armed && !triggered));

    // R2
    disarm_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_wr |=> (!armed && !triggered));

    // R11
    trig_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    // R11
    pulse_means_fired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig || bkpt_req) |-> (triggered && !armed));

    // R11
    fired_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> (trig || bkpt_req));

    // R11
    armed_fired_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && triggered));

    // R12
    bkpt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |=> !bkpt_req);

    // R12
    trace_bkpt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig && bkpt_req));

endmodule

bind bus_trig_unit btu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .trig      (trig),
    .bkpt_req  (bkpt_req),
    .armed     (armed),
    .triggered (triggered)
);

// File: tb/bus_trig_unit_bench.sv
module bus_trig_unit_bench;

    localparam int unsigned W = 16;
    localparam logic [15:0] CA = 16'd5;
    localparam logic [15:0] CB = 16'd10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         bus_valid = 1'b0;
    logic         bus_rw = 1'b0;
    logic [W-1:0] bus_addr = '0;
    logic [W-1:0] bus_data = '0;
    logic         trig, trig_begin, bkpt_req, bkpt_swi, armed, triggered;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bus_trig_unit #(.W(W)) u_bus_trig_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_valid(bus_valid), .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_data(bus_data),
        .trig(trig), .trig_begin(trig_begin), .bkpt_req(bkpt_req), .bkpt_swi(bkpt_swi),
        .armed(armed), .triggered(triggered)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns one falling edge later
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive_bus(input logic v, input logic rw, input logic [15:0] ad, input logic [15:0] da);
        bus_valid = v; bus_rw = rw; bus_addr = ad; bus_data = da;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // q=1: A matches reads only, B matches writes only
    function automatic logic exp_trace(input int m, input bit q, input logic v, input logic rw,
                                       input logic [15:0] ad, input logic [15:0] da);
        logic aq, bq, ah, bh, bany;
        aq   = q ? (rw == 1'b1) : 1'b1;
        bq   = q ? (rw == 1'b0) : 1'b1;
        ah   = v && (ad == CA) && aq;
        bh   = v && (ad == CB) && bq;
        bany = v && (ad == CB);
        case (m)
            0:       return ah;
            1:       return ah || bh;
            3:       return bany;
            5:       return ah && (da == CB);
            6:       return ah && (da != CB);
            7:       return v && aq && (ad >= CA) && (ad <= CB);
            8:       return v && aq && ((ad < CA) || (ad > CB));
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int m);
        case (m)
            0, 3:    return "R3";
            1:       return "R4";
            2, 4:    return "R5";
            5, 6:    return "R6";
            7, 8:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (R11): actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", trig, 1'b0);
        chk("R1", bkpt_req, 1'b0);
        chk("R1", armed, 1'b0);
        chk("R1", triggered, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        wr(2'd2, CA);
        wr(2'd3, CB);

        // trace condition sweep; q selects R9 direction qualifiers, v=0 covers R10
        for (int q = 0; q < 2; q++) begin
            for (int m = 0; m < 16; m++) begin
                wr(2'd1, 16'(m) | (q != 0 ? 16'h0070 : 16'h0000));
                for (int a = 0; a < 16; a++) begin
                    for (int di = 0; di < 2; di++) begin
                        for (int rw = 0; rw < 2; rw++) begin
                            for (int v = 0; v < 2; v++) begin
                                logic e;
                                logic bg;
                                string rq;
                                bg = 1'(a & 1);
                                wr(2'd0, 16'h0001 | (16'(bg) << 4));
                                chk("R13", trig_begin, bg);
                                e  = exp_trace(m, q != 0, 1'(v), 1'(rw), 16'(a), di == 0 ? CB : 16'd3);
                                rq = (q != 0) ? {req_of(m), "/R9"} : req_of(m);
                                drive_bus(1'(v), 1'(rw), 16'(a), di == 0 ? CB : 16'd3);
                                chk(rq, trig, e);
                                chk("R11", armed, !e);
                                chk("R11", triggered, e);
                                chk("R12", bkpt_req, 1'b0);
                            end
                        end
                    end
                end
            end
        end

        // R5 sequence, then R11 one-shot
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0001);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        chk("R5", trig, 1'b0);
        chk("R5", armed, 1'b1);
        drive_bus(1'b0, 1'b0, CB, 16'd0);
        chk("R10", trig, 1'b0);
        drive_bus(1'b1, 1'b0, CB, 16'd0);
        chk("R5", trig, 1'b1);
        drive_bus(1'b1, 1'b0, CB, 16'd0);
        chk("R11", trig, 1'b0);
        chk("R11", triggered, 1'b1);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        chk("R11", trig, 1'b0);

        // R9 B qualifier (writes only) honoured by condition 2
        wr(2'd1, 16'h0042);
        wr(2'd0, 16'h0001);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        drive_bus(1'b1, 1'b1, CB, 16'd0);
        chk("R9", trig, 1'b0);
        drive_bus(1'b1, 1'b0, CB, 16'd0);
        chk("R9", trig, 1'b1);

        // R5 condition 4 ignores B qualifier
        wr(2'd1, 16'h0044);
        wr(2'd0, 16'h0001);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        drive_bus(1'b1, 1'b1, CB, 16'd0);
        chk("R5", trig, 1'b1);

        // R5 A and B equal: first cycle records, second fires
        wr(2'd3, CA);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0001);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        chk("R5", trig, 1'b0);
        chk("R5", armed, 1'b1);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        chk("R5", trig, 1'b1);
        wr(2'd3, CB);

        // R14 mode write discards A half
        wr(2'd0, 16'h0001);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        wr(2'd1, 16'd2);
        drive_bus(1'b1, 1'b0, CB, 16'd0);
        chk("R14", trig, 1'b0);
        chk("R14", armed, 1'b1);
        // R14 re-arm discards A half
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        wr(2'd0, 16'h0001);
        drive_bus(1'b1, 1'b0, CB, 16'd0);
        chk("R14", trig, 1'b0);
        // R14 disarm discards A half
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        wr(2'd0, 16'h0000);
        chk("R2", armed, 1'b0);
        wr(2'd0, 16'h0001);
        drive_bus(1'b1, 1'b0, CB, 16'd0);
        chk("R14", trig, 1'b0);

        // R2 write beats same-cycle hit
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0001);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0001;
        bus_valid = 1'b1; bus_rw = 1'b0; bus_addr = CA; bus_data = 16'd0;
        @(negedge clk);
        wr_en = 1'b0; bus_valid = 1'b0;
        chk("R2", trig, 1'b0);
        chk("R2", armed, 1'b1);
        // R2 disarm clears triggered, disarmed unit ignores hits
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        chk("R2", triggered, 1'b1);
        wr(2'd0, 16'h0000);
        chk("R2", triggered, 1'b0);
        chk("R2", armed, 1'b0);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        chk("R2", trig, 1'b0);

        // R12 breakpoint sweep, condition field set to an unused code
        wr(2'd1, 16'd12);
        for (int fu = 0; fu < 2; fu++) begin
            for (int sw = 0; sw < 2; sw++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int di = 0; di < 2; di++) begin
                        for (int rw = 0; rw < 2; rw++) begin
                            logic e;
                            logic [15:0] dv;
                            dv = (di == 0) ? CB : 16'd3;
                            wr(2'd0, 16'h0003 | (16'(sw) << 2) | (16'(fu) << 3));
                            chk("R12", bkpt_swi, 1'(sw));
                            e = (fu != 0) ? ((16'(a) == CA) && (dv == CB))
                                          : ((16'(a) == CA) || (16'(a) == CB));
                            drive_bus(1'b1, 1'(rw), 16'(a), dv);
                            chk("R12", bkpt_req, e);
                            chk("R12", trig, 1'b0);
                            chk("R11", triggered, e);
                        end
                    end
                end
            end
        end
        // R12 request lasts one cycle
        wr(2'd0, 16'h0003);
        drive_bus(1'b1, 1'b0, CA, 16'd0);
        chk("R12", bkpt_req, 1'b1);
        @(negedge clk);
        chk("R12", bkpt_req, 1'b0);

        summary();
        $finish;
    end

endmodule